// File: doc/BRIEF.md
# Multi-Buffer CAN Transmit Scheduler

This block owns the control state of three outgoing CAN message slots. Software marks a slot ready with a register-write strobe, or a board-level request line is pulled low to do the same. Whenever no attempt is in flight, the scheduler picks one ready slot by a programmable 2-bit priority. It then presents the slot's index to the protocol engine with a one-cycle start strobe. The engine answers with exactly one result pulse for the attempt: delivered, lost arbitration, or bus error.

For each slot the scheduler keeps four flags: pending, lost arbitration, transmit error and aborted. It also raises a per-slot completion pulse that serves as the transmit-done interrupt. In normal operation a failed attempt leaves the slot pending, so it is retried automatically. In single-attempt mode a failure retires the request. An abort strobe withdraws every waiting request at once. The slot on the bus finishes its attempt first and is withdrawn only if that attempt fails. Message storage and bit serialization are outside this block.

Top module: `can_tx_sched`

## Requirements
- R1: After reset, all pending, lost-arbitration, error, aborted and done flags are 0, and `start_o` is 0.
- R2: A pulse on `req_wr_i[i]` makes `pend_o[i]` 1 on the next cycle and clears `aborted_o[i]`.
- R3: Each request line is active low and passes through two synchronizing flops. A high-to-low transition sets the slot pending at the third rising clock edge after the line falls. A line held low triggers only once. A line whose `pin_gpio_i` bit is 1 never sets a request.
- R4: When no attempt is in flight and at least one slot is pending, `start_o` pulses for one cycle on the next cycle, with `sel_idx_o` naming the winning slot. Slot i's priority is `prio_i[2i+1:2i]`. The larger value wins, and on a tie the higher slot index wins. A new attempt starts only after the current one has returned a result.
- R5: A success result (`eng_ok_i`) clears the active slot's pending, lost-arbitration and error flags, and pulses `done_irq_o` for that slot for one cycle.
- R6: `eng_arb_lost_i` sets the active slot's lost-arbitration flag, and `eng_err_i` sets its error flag. With single-attempt mode off and no abort, the slot stays pending and is started again.
- R7: With `one_shot_i` high, a failed attempt clears the active slot's pending flag.
- R8: `abort_i` clears the pending flag of every slot not on the bus on the next cycle, and sets the aborted flag of each slot it cleared. An abort overrides a request strobe for the same slot in the same cycle, and no attempt starts in a cycle in which `abort_i` is high.
- R9: An abort during an attempt leaves the active slot pending until its result arrives. A failure then clears its pending flag and sets its aborted flag. A success is handled as in R5.
- R10: Result pulses arriving while no attempt is in flight change no flag. A result for the active slot takes precedence over a request strobe for that slot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr_i | input | 3 | Register-write request strobes, one per slot |
| req_pin_n_i | input | 3 | Active-low asynchronous request lines |
| pin_gpio_i | input | 3 | 1 = the matching line is a plain input and does not request |
| prio_i | input | 6 | Slot priorities, 2 bits per slot, slot i at [2i+1:2i] |
| one_shot_i | input | 1 | Single-attempt mode |
| abort_i | input | 1 | Abort strobe |
| eng_ok_i | input | 1 | Engine result: message delivered |
| eng_arb_lost_i | input | 1 | Engine result: arbitration lost |
| eng_err_i | input | 1 | Engine result: bus error |
| start_o | output | 1 | One-cycle start strobe to the engine |
| sel_idx_o | output | 2 | Index of the slot being sent |
| pend_o | output | 3 | Per-slot pending flag |
| lost_arb_o | output | 3 | Per-slot lost-arbitration flag |
| tx_err_o | output | 3 | Per-slot transmit-error flag |
| aborted_o | output | 3 | Per-slot aborted flag |
| done_irq_o | output | 3 | Per-slot one-cycle completion pulse |

## Verification
The embedded properties check, on every cycle, the local rules of each slot. A start always names a pending slot. At most one completion pulse is active at a time. A completion leaves its slot clean. A request rises only from a request cause. A failure either keeps or drops the request, depending on the retry mode. An abort empties every slot that is not on the bus.

Several behaviours only show up across whole scenarios. These are the priority and tie choice among several pending slots, the exact latency of the synchronized pin path, and masking of lines configured as plain inputs. They also include the hand-off between an abort and the attempt still in flight, and the dropping of stray results. The bench covers them by running a cycle-level model next to the design under directed and random traffic.

// File: rtl/can_tx_sched_pkg.sv
package can_tx_sched_pkg;

    localparam int TXS_NUM_BUF     = 3;
    localparam int TXS_PRIO_W      = 2;
    localparam int TXS_SYNC_STAGES = 2;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic ok;
        logic arb_lost;
        logic bus_err;
    } eng_result_t;

    typedef struct packed {
        logic pend;
        logic lost_arb;
        logic tx_err;
        logic aborted;
    } slot_status_t;

    function automatic logic any_result(input eng_result_t r);
        return r.ok | r.arb_lost | r.bus_err;
    endfunction

endpackage

// File: rtl/can_tx_pin_sync.sv
module can_tx_pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_n_i,
    input  logic [N-1:0] gpio_i,
    output logic [N-1:0] fall_o
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        // stages 0..STAGES-1 synchronize, stage STAGES holds the previous value
        logic [STAGES:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= '1;
            else     chain_q <= {chain_q[STAGES-1:0], pin_n_i[g]};
        end
        assign fall_o[g] = chain_q[STAGES] & ~chain_q[STAGES-1] & ~gpio_i[g];
    end
endmodule

// File: rtl/can_tx_prio_arb.sv
module can_tx_prio_arb #(
    parameter int N  = 3,
    parameter int PW = 2,
    parameter int IW = 2
) (
    input  logic [N-1:0]    req_i,
    input  logic [N*PW-1:0] prio_i,
    output logic            valid_o,
    output logic [IW-1:0]   idx_o
);
    logic [PW-1:0] best;
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        // ascending scan with >= lets the higher index take a tie
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && (!valid_o || prio_i[i*PW +: PW] >= best)) begin
                valid_o = 1'b1;
                idx_o   = IW'(i);
                best    = prio_i[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/can_tx_slot.sv
module can_tx_slot
    import can_tx_sched_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         set_req_i,
    input  logic         abort_now_i,
    input  logic         ok_i,
    input  logic         fail_i,
    input  logic         arb_i,
    input  logic         err_i,
    input  logic         drop_i,
    input  logic         mark_abort_i,
    output slot_status_t status_o,
    output logic         done_o
);
    slot_status_t st_q;
    logic         done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ok_i) begin
                st_q.pend     <= 1'b0;
                st_q.lost_arb <= 1'b0;
                st_q.tx_err   <= 1'b0;
                done_q        <= 1'b1;
            end else if (fail_i) begin
                st_q.lost_arb <= st_q.lost_arb | arb_i;
                st_q.tx_err   <= st_q.tx_err | err_i;
                if (drop_i)       st_q.pend    <= 1'b0;
                if (mark_abort_i) st_q.aborted <= 1'b1;
            end else if (abort_now_i) begin
                if (st_q.pend) st_q.aborted <= 1'b1;
                st_q.pend <= 1'b0;
            end else if (set_req_i) begin
                st_q.pend    <= 1'b1;
                st_q.aborted <= 1'b0;
            end
        end
    end

    assign status_o = st_q;
    assign done_o   = done_q;

    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!st_q.pend && !st_q.lost_arb && !st_q.tx_err)); // R5
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.pend) |-> $past(set_req_i)); // R2
    AST_RETRY_KEEP: assert property (@(posedge clk) disable iff (rst)
        (fail_i && !drop_i) |=> st_q.pend); // R6
    AST_FAIL_DROP: assert property (@(posedge clk) disable iff (rst)
        (fail_i && drop_i) |=> !st_q.pend); // R7
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort_now_i |=> !st_q.pend); // R8
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
    import can_tx_sched_pkg::*;
#(
    parameter int NUM_BUF     = TXS_NUM_BUF,
    parameter int PRIO_W      = TXS_PRIO_W,
    parameter int SYNC_STAGES = TXS_SYNC_STAGES,
    localparam int IDX_W      = $clog2(NUM_BUF)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_BUF-1:0]        req_wr_i,
    input  logic [NUM_BUF-1:0]        req_pin_n_i,
    input  logic [NUM_BUF-1:0]        pin_gpio_i,
    input  logic [NUM_BUF*PRIO_W-1:0] prio_i,
    input  logic                      one_shot_i,
    input  logic                      abort_i,
    input  logic                      eng_ok_i,
    input  logic                      eng_arb_lost_i,
    input  logic                      eng_err_i,
    output logic                      start_o,
    output logic [IDX_W-1:0]          sel_idx_o,
    output logic [NUM_BUF-1:0]        pend_o,
    output logic [NUM_BUF-1:0]        lost_arb_o,
    output logic [NUM_BUF-1:0]        tx_err_o,
    output logic [NUM_BUF-1:0]        aborted_o,
    output logic [NUM_BUF-1:0]        done_irq_o
);
    seq_state_t        state_q;
    logic [IDX_W-1:0]  sel_q;
    logic              start_q;
    logic              abort_lat_q;
    eng_result_t       res;
    logic              res_seen;
    logic [NUM_BUF-1:0] pin_fall;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;

    assign res      = '{ok: eng_ok_i, arb_lost: eng_arb_lost_i, bus_err: eng_err_i};
    assign res_seen = (state_q == SEQ_BUSY) && any_result(res);

    can_tx_pin_sync #(.N(NUM_BUF), .STAGES(SYNC_STAGES)) u_pins (
        .clk(clk), .rst(rst), .pin_n_i(req_pin_n_i), .gpio_i(pin_gpio_i), .fall_o(pin_fall)
    );

    can_tx_prio_arb #(.N(NUM_BUF), .PW(PRIO_W), .IW(IDX_W)) u_arb (
        .req_i(pend_o), .prio_i(prio_i), .valid_o(win_valid), .idx_o(win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SEQ_IDLE;
            sel_q       <= '0;
            start_q     <= 1'b0;
            abort_lat_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (state_q == SEQ_IDLE) begin
                abort_lat_q <= 1'b0;
                if (win_valid && !abort_i) begin
                    state_q <= SEQ_BUSY;
                    sel_q   <= win_idx;
                    start_q <= 1'b1;
                end
            end else if (res_seen) begin
                state_q     <= SEQ_IDLE;
                abort_lat_q <= 1'b0;
            end else if (abort_i) begin
                abort_lat_q <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
        logic         mine;
        slot_status_t st;
        logic         done;
        assign mine = (state_q == SEQ_BUSY) && (sel_q == IDX_W'(g));

        can_tx_slot u_slot (
            .clk(clk), .rst(rst),
            .set_req_i(req_wr_i[g] | pin_fall[g]),
            .abort_now_i(abort_i && !mine),
            .ok_i(mine && res.ok),
            .fail_i(mine && !res.ok && (res.arb_lost || res.bus_err)),
            .arb_i(res.arb_lost),
            .err_i(res.bus_err),
            .drop_i(one_shot_i | abort_lat_q | abort_i),
            .mark_abort_i(abort_lat_q | abort_i),
            .status_o(st),
            .done_o(done)
        );

        assign pend_o[g]     = st.pend;
        assign lost_arb_o[g] = st.lost_arb;
        assign tx_err_o[g]   = st.tx_err;
        assign aborted_o[g]  = st.aborted;
        assign done_irq_o[g] = done;
    end

    assign start_o   = start_q;
    assign sel_idx_o = sel_q;

    AST_START_PENDING: assert property (@(posedge clk) disable iff (rst)
        start_o |-> pend_o[sel_idx_o]); // R4
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        start_o |-> !$past(start_o)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done_irq_o)); // R5
    AST_NO_START_ON_ABORT: assert property (@(posedge clk) disable iff (rst)
        $past(abort_i) |-> !start_o); // R8
endmodule

// File: tb/tb_can_tx_sched.sv
module tb_can_tx_sched;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] req_wr = '0, pin_n = '1, gpio = '0;
    logic [5:0] prio = '0;
    logic       one_shot = 1'b0, abort = 1'b0, e_ok = 1'b0, e_arb = 1'b0, e_err = 1'b0;
    logic       start;
    logic [1:0] sel;
    logic [2:0] pend, lost, terr, abtd, done;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    // bench model state
    bit [2:0] m_req, m_lost, m_err, m_abt, m_done, s1, s2, pv;
    bit       m_act, m_start, m_alat;
    bit [1:0] m_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_tx_sched dut (
        .clk(clk), .rst(rst), .req_wr_i(req_wr), .req_pin_n_i(pin_n), .pin_gpio_i(gpio),
        .prio_i(prio), .one_shot_i(one_shot), .abort_i(abort), .eng_ok_i(e_ok),
        .eng_arb_lost_i(e_arb), .eng_err_i(e_err), .start_o(start), .sel_idx_o(sel),
        .pend_o(pend), .lost_arb_o(lost), .tx_err_o(terr), .aborted_o(abtd), .done_irq_o(done)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [1:0] winner(input bit [2:0] r, input bit [5:0] p);
        bit [1:0] w = 0;
        bit [1:0] b = 0;
        bit v = 0;
        for (int i = 0; i < 3; i++)
            if (r[i] && (!v || p[i*2 +: 2] >= b)) begin
                v = 1; w = 2'(i); b = p[i*2 +: 2];
            end
        return w;
    endfunction

    // next state from the requirements, using the inputs now driven
    task automatic model_adv();
        bit [2:0] fall = pv & ~s2 & ~gpio;
        bit [2:0] setv = req_wr | fall;
        bit res = m_act && (e_ok || e_arb || e_err);
        bit [2:0] nreq = m_req, nlost = m_lost, nerr = m_err, nabt = m_abt, ndone = 0;
        bit nact = m_act, nst = 0, nalat = 0;
        bit [1:0] nsel = m_sel;
        for (int i = 0; i < 3; i++) begin
            bit mine = m_act && (m_sel == 2'(i));
            if (mine && e_ok) begin
                nreq[i] = 0; nlost[i] = 0; nerr[i] = 0; ndone[i] = 1;       // R5
            end else if (mine && (e_arb || e_err)) begin                     // R6
                if (e_arb) nlost[i] = 1;
                if (e_err) nerr[i] = 1;
                if (one_shot || m_alat || abort) nreq[i] = 0;               // R7 R9
                if (m_alat || abort) nabt[i] = 1;
            end else if (abort && !mine) begin                               // R8
                if (m_req[i]) nabt[i] = 1;
                nreq[i] = 0;
            end else if (setv[i]) begin                                      // R2 R3
                nreq[i] = 1; nabt[i] = 0;
            end
        end
        if (m_act) begin
            if (res) nact = 0;
            else if (abort) nalat = 1;
            else nalat = m_alat;
        end else if (!abort && m_req != 0) begin                             // R4
            nact = 1; nsel = winner(m_req, prio); nst = 1;
        end
        s1 = pin_n; s2 = s1_prev_hack(s1); pv = pv;
        m_req = nreq; m_lost = nlost; m_err = nerr; m_abt = nabt; m_done = ndone;
        m_act = nact; m_sel = nsel; m_start = nst; m_alat = nalat;
    endtask

    function automatic bit [2:0] s1_prev_hack(input bit [2:0] x);
        return x;
    endfunction

    task automatic compare_all();
        chk("R2 R3 R7 R8 R9 R10 pend", {5'd0, pend}, {5'd0, m_req});
        chk("R6 R10 lost_arb", {5'd0, lost}, {5'd0, m_lost});
        chk("R6 R10 tx_err", {5'd0, terr}, {5'd0, m_err});
        chk("R8 R9 aborted", {5'd0, abtd}, {5'd0, m_abt});
        chk("R5 done_irq", {5'd0, done}, {5'd0, m_done});
        chk("R4 start", {7'd0, start}, {7'd0, m_start});
        if (m_start) chk("R4 sel_idx", {6'd0, sel}, {6'd0, m_sel});
    endtask

    // apply current stimulus across one rising edge, then compare
    task automatic step();
        bit [2:0] os1 = s1, os2 = s2;
        model_adv();
        s2 = os1; pv = os2;
        @(negedge clk);
        compare_all();
    endtask

    task automatic clear_stim();
        req_wr = 0; abort = 0; e_ok = 0; e_arb = 0; e_err = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_req = 0; m_lost = 0; m_err = 0; m_abt = 0; m_done = 0;
        m_act = 0; m_start = 0; m_alat = 0; m_sel = 0; s1 = '1; s2 = '1; pv = '1;
        // R1 reset state
        chk("R1 reset flags", {pend, lost}, 8'h00);
        chk("R1 reset flags2", {terr, abtd}, 8'h00);
        chk("R1 reset done/start", {4'd0, done, start}, 8'h00);

        // R3: a line configured as plain input never requests
        gpio = 3'b100; pin_n = 3'b011;
        repeat (5) step();
        chk("R3 gpio line ignored", {5'd0, pend}, 8'h00);
        pin_n = 3'b111;
        repeat (3) step();
        gpio = 3'b000;
        step();

        // R3: enabled line, pending at third edge after the fall
        pin_n = 3'b110;
        step(); step();
        chk("R3 not yet pending", {7'd0, pend[0]}, 8'h00);
        step();
        chk("R3 pin request", {7'd0, pend[0]}, 8'h01);
        step();                      // start for slot 0
        e_ok = 1; step(); clear_stim();
        chk("R5 done slot0", {5'd0, done}, 8'h01);
        pin_n = 3'b111;
        repeat (4) step();
        chk("R3 held low no retrigger", {5'd0, pend}, 8'h00);

        // R4: tie goes to higher index; b0=3, b1=3, b2=1
        prio = {2'd1, 2'd3, 2'd3};
        req_wr = 3'b111; step(); clear_stim();
        step();
        chk("R4 tie pick", {7'd0, start}, 8'h01);
        chk("R4 tie index", {6'd0, sel}, 8'h01);
        e_ok = 1; step(); clear_stim();
        step();
        chk("R4 next by priority", {6'd0, sel}, 8'h00);
        e_arb = 1; step(); clear_stim();
        chk("R6 retry keeps pending", {7'd0, pend[0]}, 8'h01);
        // R9: abort while slot 0 is on the bus
        step();
        abort = 1; step(); clear_stim();
        chk("R9 active stays pending", {7'd0, pend[0]}, 8'h01);
        chk("R8 waiting slot aborted", {5'd0, abtd}, 8'h04);
        e_err = 1; step(); clear_stim();
        chk("R9 fail drops active", {5'd0, pend}, 8'h00);
        // R10: stray result while idle
        e_ok = 1; e_err = 1; step(); clear_stim();
        step();

        // random phase
        for (int n = 0; n < 8000; n++) begin
            clear_stim();
            if (n % 400 == 0) one_shot = $urandom_range(0, 1) == 1;
            if ($urandom_range(0, 49) == 0) prio = 6'($urandom);
            if ($urandom_range(0, 199) == 0) gpio = 3'($urandom);
            for (int i = 0; i < 3; i++) begin
                if ($urandom_range(0, 11) == 0) req_wr[i] = 1;
                if ($urandom_range(0, 15) == 0) pin_n[i] = ~pin_n[i];
            end
            if ($urandom_range(0, 39) == 0) abort = 1;
            if (m_act ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 29) == 0)) begin
                case ($urandom_range(0, 3))
                    0, 1: e_ok = 1;
                    2:    e_arb = 1;
                    default: begin e_err = 1; e_arb = $urandom_range(0, 1) == 1; end
                endcase
            end
            step();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule